// File: doc/BRIEF.md
# Synchronous Transfer Strobe Pacer

This block times the request strobes of a synchronous data phase. Each data byte gets one single-cycle REQ strobe. Strobes are spaced by a period chosen from a 4-bit code. The count of strobes still waiting for an acknowledge is capped by a 4-bit offset. Both fields arrive together in one configuration byte. The block does not carry data. It only decides in which cycle each byte may be offered, and it reports when the whole transfer has been offered and acknowledged.

Software or a sequencer sets the configuration byte and the byte count, then raises the enable. The far side returns one single-cycle ACK pulse per strobe. An offset of zero gives a fully interlocked exchange, where every strobe waits for the acknowledge of the one before it. A configuration of 0x02 is the usual setting for asynchronous transfers: offset 0 with period code 2. The done flag stays up until the enable is dropped. Dropping the enable earlier abandons the transfer.

Top module: `sync_req_pacer`

## Requirements
- R1: The offset is xfer_cfg[7:4] and the period code is xfer_cfg[3:0]. Both are sampled on the clock edge where xfer_en is seen high while idle. Changes to xfer_cfg while a transfer is running or done have no effect.
- R2: For a nonzero period code c, strobes are at least 2*(c+2) cycles apart. When the acknowledge limit does not hold a strobe back, they are exactly that far apart.
- R3: Period code 0 gives a strobe spacing of 5 cycles, not 4.
- R4: For an offset k of 1 or more, strobes issued minus acknowledges received never exceeds k. A strobe that would exceed it is held until an acknowledge arrives, and may then go out in the cycle after that acknowledge.
- R5: With offset 0, a strobe waits for the acknowledge of the previous strobe. The earliest next strobe is the cycle after that acknowledge, and the period also applies.
- R6: Exactly xfer_len strobes are issued, each one cycle wide. The first one comes in the cycle right after the starting edge.
- R7: xfer_done rises two cycles after the last acknowledge pulse, once all strobes have been issued. With xfer_len of 0 it rises two cycles after the start. It holds while xfer_en stays high, and clears one cycle after xfer_en falls.
- R8: An acknowledge pulse that arrives while no strobe is outstanding is ignored and does not create extra credit.
- R9: Dropping xfer_en during a transfer ends it. No further strobes are issued and xfer_done does not rise.
- R10: req_strobe stays low whenever no transfer is running, including right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_cfg | input | 8 | Offset in the upper nibble, period code in the lower nibble |
| xfer_en | input | 1 | Starts a transfer when raised; held high for its duration |
| xfer_len | input | 16 | Number of bytes to strobe |
| ack_pulse | input | 1 | One-cycle acknowledge from the far side |
| req_strobe | output | 1 | One-cycle request strobe per byte |
| xfer_done | output | 1 | All bytes strobed and acknowledged |

## Verification
The hardest case to reach from the ports is a stray acknowledge that arrives during a running transfer while the credit count is already zero. It only exposes a wrapping counter if the strobes that follow depend on that credit. The stimulus uses offset 0 with the longest period code and a one-cycle acknowledge latency. This leaves a long window with nothing outstanding, and a spurious pulse is injected into that window. The credit-limited case is reached with an acknowledge latency much longer than the period, which fills the offset and forces irregular gaps whose lengths are worked out by hand.

// File: rtl/sreq_pkg.sv
// Shared types for the synchronous strobe pacer.
package sreq_pkg;
    // Transfer sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } xfer_state_t;
endpackage

// File: rtl/sreq_cfg_hold.sv
// Holds the configuration byte for the duration of a transfer and decodes it.
// Assumes: hold is high from the cycle after the starting edge until the block
// returns to idle, so the byte captured on the starting edge stays in force.
module sreq_cfg_hold #(
    parameter int OFS_W = 4,
    parameter int PER_W = 4,
    parameter int TMR_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hold,
    input  logic [OFS_W+PER_W-1:0] cfg_in,
    output logic [OFS_W+PER_W-1:0] cfg_q,
    output logic [OFS_W-1:0]       limit,
    output logic [TMR_W-1:0]       period
);
    localparam int CFG_W = OFS_W + PER_W;

    logic [OFS_W-1:0] ofs_f;
    logic [PER_W-1:0] per_f;

    // Track the input while idle, freeze it while a transfer is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (!hold) begin
            cfg_q <= cfg_in;
        end
    end

    // Decode offset into a credit limit and period code into cycles.
    always_comb begin
        ofs_f  = cfg_q[CFG_W-1:PER_W];
        per_f  = cfg_q[PER_W-1:0];
        limit  = (ofs_f == '0) ? OFS_W'(1) : ofs_f;
        if (per_f == '0) begin
            period = TMR_W'(5);
        end else begin
            period = TMR_W'({per_f, 1'b0}) + TMR_W'(4);
        end
    end
endmodule

// File: rtl/sreq_pace_timer.sv
// Counts down the minimum spacing between two strobes.
// Assumes: period is at least 1; clear forces the timer ready.
module sreq_pace_timer #(
    parameter int TMR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             fire,
    input  logic [TMR_W-1:0] period,
    output logic             ready
);
    logic [TMR_W-1:0] cnt_q;

    // Reload on a strobe, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (fire) begin
            cnt_q <= period - TMR_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TMR_W'(1);
        end
    end

    assign ready = (cnt_q == '0);
endmodule

// File: rtl/sreq_credit_ctr.sv
// Counts strobes not yet acknowledged and reports whether another may go out.
// Assumes: inc never fires when room is low; a decrement at zero is dropped.
module sreq_credit_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    input  logic         dec,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         room,
    output logic         empty
);
    // Apply strobe and acknowledge events; ignore acknowledges with nothing owed.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (inc && !dec) begin
            count <= count + W'(1);
        end else if (dec && !inc && count != '0) begin
            count <= count - W'(1);
        end
    end

    assign room  = (count < limit);
    assign empty = (count == '0);
endmodule

// File: rtl/sync_req_pacer.sv
// Top level: sequences one synchronous transfer, issuing one strobe per byte
// subject to the period timer and the outstanding-credit limit.
// Assumes: xfer_en is held high for the whole transfer and dropped to leave done.
module sync_req_pacer
    import sreq_pkg::*;
#(
    parameter int OFS_W = 4,
    parameter int PER_W = 4,
    parameter int CNT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [OFS_W+PER_W-1:0] xfer_cfg,
    input  logic                   xfer_en,
    input  logic [CNT_W-1:0]       xfer_len,
    input  logic                   ack_pulse,
    output logic                   req_strobe,
    output logic                   xfer_done
);
    localparam int CFG_W = OFS_W + PER_W;
    localparam int TMR_W = $clog2(2 * ((1 << PER_W) + 1) + 1);

    xfer_state_t      state_q;
    logic [CNT_W-1:0] remain_q;
    logic [CFG_W-1:0] cfg_q;
    logic [OFS_W-1:0] cred_limit;
    logic [OFS_W-1:0] credit_cnt;
    logic [TMR_W-1:0] pace_period;
    logic             run_st;
    logic             pace_ready;
    logic             cred_room;
    logic             cred_empty;
    logic             start_x;
    logic             finish_x;

    assign run_st   = (state_q == ST_RUN);
    assign start_x  = (state_q == ST_IDLE) && xfer_en;
    assign finish_x = run_st && xfer_en && (remain_q == '0) && cred_empty;

    sreq_cfg_hold #(
        .OFS_W (OFS_W),
        .PER_W (PER_W),
        .TMR_W (TMR_W)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (state_q != ST_IDLE),
        .cfg_in (xfer_cfg),
        .cfg_q  (cfg_q),
        .limit  (cred_limit),
        .period (pace_period)
    );

    sreq_pace_timer #(
        .TMR_W (TMR_W)
    ) u_pace (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!run_st),
        .fire   (req_strobe),
        .period (pace_period),
        .ready  (pace_ready)
    );

    sreq_credit_ctr #(
        .W (OFS_W)
    ) u_cred (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!run_st),
        .inc   (req_strobe),
        .dec   (ack_pulse),
        .limit (cred_limit),
        .count (credit_cnt),
        .room  (cred_room),
        .empty (cred_empty)
    );

    // Strobe when running, bytes remain, spacing has elapsed and credit allows.
    always_comb begin
        req_strobe = run_st && (remain_q != '0) && pace_ready && cred_room;
    end

    // Transfer state sequencing: start, abandon, completion and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (xfer_en)   state_q <= ST_RUN;
                ST_RUN:  begin
                    if (!xfer_en)       state_q <= ST_IDLE;
                    else if (finish_x)  state_q <= ST_DONE;
                end
                ST_DONE: if (!xfer_en)  state_q <= ST_IDLE;
                default:                state_q <= ST_IDLE;
            endcase
        end
    end

    // Bytes still to be strobed in this transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (start_x) begin
            remain_q <= xfer_len;
        end else if (req_strobe) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end

    assign xfer_done = (state_q == ST_DONE);
endmodule

// File: rtl/sreq_pacer_chk.sv
// Property checker for the strobe pacer, bound into every instance.
// Assumes: period and credit come from the pacer's own timer and counter decode.
module sreq_pacer_chk #(
    parameter int OFS_W = 4,
    parameter int PER_W = 4,
    parameter int TMR_W = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_strobe,
    input logic                   xfer_done,
    input logic                   run_st,
    input logic [OFS_W-1:0]       credit,
    input logic [OFS_W-1:0]       limit,
    input logic [TMR_W-1:0]       period,
    input logic [OFS_W+PER_W-1:0] cfg_q
);
    localparam int GAP_W = TMR_W + 1;

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    // Independent count of cycles since the last strobe of this transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_st) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (req_strobe) begin
            gap_q  <= GAP_W'(1);
            seen_q <= 1'b1;
        end else if (gap_q != {GAP_W{1'b1}}) begin
            gap_q  <= gap_q + GAP_W'(1);
        end
    end

    AST_REQ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (req_strobe && seen_q) |-> (gap_q >= GAP_W'(period))); // R2
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_strobe |=> !req_strobe); // R6
    AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        credit <= limit); // R4
    AST_OFS0_INTERLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_q[OFS_W+PER_W-1:PER_W] == '0) && (credit != '0)) |-> !req_strobe); // R5
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_st && $past(run_st)) |-> $stable(cfg_q)); // R1
    AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> ((credit == '0) && !req_strobe)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run_st |-> !req_strobe); // R10
endmodule

bind sync_req_pacer sreq_pacer_chk #(
    .OFS_W (OFS_W),
    .PER_W (PER_W),
    .TMR_W (TMR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_strobe (req_strobe),
    .xfer_done  (xfer_done),
    .run_st     (run_st),
    .credit     (credit_cnt),
    .limit      (cred_limit),
    .period     (pace_period),
    .cfg_q      (cfg_q)
);

// File: tb/sim_sync_req_pacer.sv
`timescale 1ns/1ps
module sim_sync_req_pacer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  xfer_cfg = 8'h00;
    logic        xfer_en = 1'b0;
    logic [15:0] xfer_len = 16'd0;
    logic        ack_pulse = 1'b0;
    logic        req_strobe;
    logic        xfer_done;

    int checks = 0;
    int failures = 0;
    bit fin = 1'b0;

    // Results of the most recent transfer run.
    int r_n, r_first, r_last, r_min, r_max, r_peak, r_done, r_hold, r_drop;
    bit hist [4096];

    localparam int NV = 9;
    localparam logic [7:0] T_CFG [NV] = '{8'h02, 8'h02, 8'h10, 8'h40, 8'h3F, 8'h25, 8'h02, 8'h00, 8'h01};
    localparam int T_CNT  [NV] = '{4, 3, 5, 6, 3, 4, 1, 4, 3};
    localparam int T_LAT  [NV] = '{3, 12, 2, 30, 1, 40, 3, 1, 1};
    localparam int T_MIN  [NV] = '{8, 13, 5, 5, 34, 14, 0, 5, 6};
    localparam int T_MAX  [NV] = '{8, 13, 5, 16, 34, 27, 0, 5, 6};
    localparam int T_PEAK [NV] = '{1, 1, 1, 4, 1, 2, 1, 1, 1};

    sync_req_pacer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_cfg   (xfer_cfg),
        .xfer_en    (xfer_en),
        .xfer_len   (xfer_len),
        .ack_pulse  (ack_pulse),
        .req_strobe (req_strobe),
        .xfer_done  (xfer_done)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One transfer: acknowledges follow each strobe after lat cycles.
    task automatic run_xfer(input logic [7:0] cfg, input int cnt, input int lat,
                            input int chg_at, input logic [7:0] chg_cfg,
                            input int stray_at, input int abort_at, input int max_cyc);
        int cyc;
        int outst;
        bit a;
        for (int i = 0; i < 4096; i++) hist[i] = 1'b0;
        r_n = 0; r_first = -1; r_last = -1; r_min = 9999; r_max = 0;
        r_peak = 0; r_done = -1; r_hold = 0; r_drop = 1;
        outst = 0;
        @(negedge clk);
        cyc = 0;
        xfer_cfg = cfg; xfer_len = cnt[15:0]; xfer_en = 1'b1; ack_pulse = 1'b0;
        while (cyc < max_cyc && r_done < 0) begin
            @(negedge clk);
            cyc++;
            if (cyc == chg_at) xfer_cfg = chg_cfg;
            if (cyc == abort_at) xfer_en = 1'b0;
            if (req_strobe) begin
                hist[cyc] = 1'b1;
                r_n++;
                if (r_first < 0) r_first = cyc;
                else begin
                    if (cyc - r_last < r_min) r_min = cyc - r_last;
                    if (cyc - r_last > r_max) r_max = cyc - r_last;
                end
                r_last = cyc;
                outst++;
                if (outst > r_peak) r_peak = outst;
            end
            a = (cyc >= lat) && hist[cyc - lat];
            if (a) outst--;
            ack_pulse = a || (cyc == stray_at);
            if (xfer_done) r_done = cyc;
        end
        ack_pulse = 1'b0;
        if (r_min == 9999) r_min = 0;
        if (r_done >= 0) begin
            r_hold = 1;
            repeat (4) begin
                @(negedge clk);
                if (!xfer_done || req_strobe) r_hold = 0;
            end
        end
        xfer_en = 1'b0;
        @(negedge clk);
        r_drop = xfer_done ? 1 : 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            failures++;
            $display("FAIL R6 watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state, nothing driven
        chk(req_strobe == 1'b0, "R10 reset req", int'(req_strobe), 0);
        chk(xfer_done == 1'b0, "R7 reset done", int'(xfer_done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_strobe == 1'b0, "R10 idle req", int'(req_strobe), 0);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            run_xfer(T_CFG[v], T_CNT[v], T_LAT[v], -1, 8'h00, -1, -1, 3000);
            chk(r_n == T_CNT[v], "R6 strobe count", r_n, T_CNT[v]);
            chk(r_first == 1, "R6 first strobe cycle", r_first, 1);
            chk(r_min == T_MIN[v], (T_CFG[v][3:0] == 4'h0) ? "R3 min gap" : "R2 min gap",
                r_min, T_MIN[v]);
            chk(r_max == T_MAX[v], (T_CFG[v][7:4] == 4'h0) ? "R5 max gap" : "R4 max gap",
                r_max, T_MAX[v]);
            chk(r_peak == T_PEAK[v], "R4 peak outstanding", r_peak, T_PEAK[v]);
            chk(r_done == r_last + T_LAT[v] + 2, "R7 done cycle", r_done, r_last + T_LAT[v] + 2);
            chk(r_hold == 1, "R7 done held", r_hold, 1);
            chk(r_drop == 0, "R7 done cleared", r_drop, 0);
        end

        // R7: zero-length transfer completes with no strobes
        run_xfer(8'h02, 0, 3, -1, 8'h00, -1, -1, 100);
        chk(r_n == 0, "R7 zero length strobes", r_n, 0);
        chk(r_done == 2, "R7 zero length done", r_done, 2);

        // R1: configuration change mid-transfer is ignored (stays 8-cycle period)
        run_xfer(8'h02, 3, 1, 3, 8'h00, -1, -1, 3000);
        chk(r_min == 8, "R1 frozen period min", r_min, 8);
        chk(r_max == 8, "R1 frozen period max", r_max, 8);

        // R8: stray acknowledge with nothing owed, offset 0, period 34
        run_xfer(8'h0F, 3, 1, -1, 8'h00, 10, -1, 3000);
        chk(r_n == 3, "R8 strobe count after stray ack", r_n, 3);
        chk(r_min == 34, "R8 gap after stray ack", r_min, 34);
        chk(r_peak == 1, "R8 peak after stray ack", r_peak, 1);

        // R9: abandon after two strobes (at cycles 1 and 9)
        run_xfer(8'h02, 5, 2, -1, 8'h00, -1, 10, 40);
        chk(r_n == 2, "R9 strobes after abandon", r_n, 2);
        chk(r_done == -1, "R9 done after abandon", r_done, -1);

        // R9/R1: a fresh transfer after abandoning picks up the new setting
        run_xfer(8'h00, 2, 1, -1, 8'h00, -1, -1, 3000);
        chk(r_n == 2, "R9 recovery strobe count", r_n, 2);
        chk(r_min == 5, "R1 new setting after idle", r_min, 5);

        fin = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule